// File: doc/BRIEF.md
# Stereo-to-TDM Audio Routing Bridge

This block sits between a two-channel serial audio world and an eight-slot time-division-multiplexed (TDM) codec link. It has three paths. In normal mode, the last stereo sample pair received on the two-channel input is written into every DAC slot of the outgoing TDM line. In both modes, the codec's TDM ADC line is split into four stereo pairs, and the pair named by a select pin goes out on a two-channel serial transmitter. In loopback mode, the first three ADC pairs return on the first three DAC pairs, and a separate external stereo ADC fills the fourth DAC pair.

Bit strobes, the TDM frame sync and the two-channel word clock all come from outside. Each strobe is a one-cycle enable in the block's master clock domain. The mode and the pair select are plain pins. Both are sampled only at a TDM frame boundary, so a frame never carries a mix of two routings.

Top module: `tdm_stereo_bridge`

## Requirements
- R1: A TDM frame is 8 slots of 32 bits (256 bit strobes). The bit strobe on which `tdmFsync` is high is frame bit index 255, which is the last bit of slot 7. The next bit strobe is index 0, the MSB of slot 0, and bit index k belongs to slot k/32.
- R2: Each DAC slot carries a 24-bit sample MSB first in slot bits 0..23, followed by 8 zero bits. On each TDM bit strobe with index k, `dacTdmOut` takes bit k and holds it until the next strobe.
- R3: With `loopMode`=0, the outgoing frame carries the left word in slots 0, 2, 4 and 6 and the right word in slots 1, 3, 5 and 7. This is the stereo pair most recently completed on `stereoIn` before the frame boundary.
- R4: An ADC slot is captured from slot bits 0..23 of `adcTdmIn`, and its 8 trailing bits are ignored. ADC pair p (1 to 4) is slots 2p-2 (left) and 2p-1 (right).
- R5: `pairSel` value v selects ADC pair v+1. That pair's left word goes out on `stereoOut` while the word clock is low, and its right word goes out while the word clock is high.
- R6: With `loopMode`=1, DAC slots 0 to 5 carry ADC slots 0 to 5 of the previous frame.
- R7: With `loopMode`=1, DAC slots 6 and 7 carry the left and right words of the pair most recently completed on `extAdcIn`.
- R8: The two-channel links use I2S framing, with the left channel while `i2sWordClk` is low. On the first word-clock strobe after a word-clock change, the transmitter drives 0 and the receivers take the previous word's last bit. On the second strobe, the 24-bit word starts MSB first. The receivers ignore the 8 bits after the 24 sample bits.
- R9: ADC data completed in frame F appears on the DAC line, or is loaded into the transmitter, starting with frame F+1.
- R10: `loopMode` and `pairSel` are sampled only on the frame-sync bit strobe. A change at any other time has no effect until the next frame boundary.
- R11: The first frame sync after reset only aligns the block. Both output lines stay 0 until the first complete frame has been received, which ends at the second frame sync.
- R12: While `rst` is high, both output lines are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Master clock |
| rst | input | 1 | Synchronous active-high reset |
| tdmBitEn | input | 1 | One-cycle strobe per TDM bit |
| tdmFsync | input | 1 | Frame sync, high on the strobe of bit index 255 |
| adcTdmIn | input | 1 | TDM data from the codec ADC |
| dacTdmOut | output | 1 | TDM data toward the codec DAC |
| i2sBitEn | input | 1 | One-cycle strobe per two-channel bit |
| i2sWordClk | input | 1 | Two-channel word clock, low for left |
| stereoIn | input | 1 | Two-channel serial input |
| extAdcIn | input | 1 | Serial data from the external stereo ADC |
| stereoOut | output | 1 | Two-channel serial transmitter output |
| loopMode | input | 1 | 0 routes stereo to TDM, 1 selects loopback |
| pairSel | input | 2 | ADC pair for the transmitter, value v selects pair v+1 |

## Verification
The hardest case to reach is a routing change that lands exactly on the frame-sync strobe, or one strobe after it. Only there does a wrong sampling point show up as a single frame built from the wrong mode or pair. The stimulus changes the select mid-frame in every frame. In chosen frames it also toggles the mode on the sync strobe itself and moves the pair select on the next cycle. The bench fills the ignored padding bits of both serial inputs with random values, so a receiver that took the wrong 24 bits shows up as corrupted samples on the outputs.

// File: rtl/tsb_pkg.sv
`timescale 1ns/1ps
package tsb_pkg;
  // Strobes from control to datapath, all one master-clock cycle wide
  typedef struct packed {
    logic tdmTick;     // TDM bit strobe
    logic slotEnd;     // last bit of a slot on this strobe
    logic frameEdge;   // frame boundary with at least one full frame behind it
    logic i2sTick;     // two-channel bit strobe
    logic wsEdge;      // word clock changed on this strobe
    logic wsNow;       // current word clock level
    logic endedRight;  // the word that just ended was the right channel
  } tsb_strobe_t;
endpackage

// File: rtl/tsb_ctrl.sv
`timescale 1ns/1ps
module tsb_ctrl
  import tsb_pkg::*;
#(
  parameter int FRAME_BITS = 256,
  parameter int SLOT_BITS  = 32,
  localparam int IDX_W  = $clog2(FRAME_BITS),
  localparam int SLOT_W = $clog2(SLOT_BITS)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              tdmBitEn,
  input  logic              tdmFsync,
  input  logic              i2sBitEn,
  input  logic              i2sWordClk,
  output tsb_strobe_t       strb,
  output logic [IDX_W-1:0]  bitIdx
);
  localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(FRAME_BITS - 1);

  logic [IDX_W-1:0] bitCnt;
  logic             synced;
  logic             wsQ;

  // The sync strobe forces the index to the last bit of the frame
  assign bitIdx = tdmFsync ? LAST_IDX : bitCnt;

  always_ff @(posedge clk) begin
    if (rst) begin
      bitCnt <= '0;
      synced <= 1'b0;
      wsQ    <= 1'b0;
    end else begin
      if (tdmBitEn) begin
        bitCnt <= (bitIdx == LAST_IDX) ? '0 : bitIdx + 1'b1;
        if (tdmFsync) synced <= 1'b1;
      end
      if (i2sBitEn) wsQ <= i2sWordClk;
    end
  end

  always_comb begin
    strb.tdmTick    = tdmBitEn;
    strb.slotEnd    = tdmBitEn && (bitIdx[SLOT_W-1:0] == '1);
    strb.frameEdge  = tdmBitEn && tdmFsync && synced;
    strb.i2sTick    = i2sBitEn;
    strb.wsEdge     = i2sBitEn && (i2sWordClk != wsQ);
    strb.wsNow      = i2sWordClk;
    strb.endedRight = wsQ;
  end

  // R1: once aligned, each sync arrives exactly one full frame after the last
  assert_fsync_period_R1: assert property (@(posedge clk) disable iff (rst)
    (tdmBitEn && tdmFsync && synced) |-> (bitCnt == LAST_IDX));
endmodule

// File: rtl/tsb_i2s_rx.sv
`timescale 1ns/1ps
module tsb_i2s_rx #(
  parameter int SLOT_BITS   = 32,
  parameter int SAMPLE_BITS = 24
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   bitTick,
  input  logic                   wsEdge,
  input  logic                   endedRight,
  input  logic                   din,
  output logic [SAMPLE_BITS-1:0] pairL,
  output logic [SAMPLE_BITS-1:0] pairR
);
  logic [SLOT_BITS-2:0]   sh;
  logic [SLOT_BITS-1:0]   word;
  logic [SAMPLE_BITS-1:0] leftQ;
  logic [SAMPLE_BITS-1:0] sample;

  // The bit on the edge strobe is the last bit of the word that just ended
  assign word   = {sh, din};
  assign sample = word[SLOT_BITS-1 -: SAMPLE_BITS];

  always_ff @(posedge clk) begin
    if (rst) begin
      sh    <= '0;
      leftQ <= '0;
      pairL <= '0;
      pairR <= '0;
    end else if (bitTick) begin
      sh <= word[SLOT_BITS-2:0];
      if (wsEdge) begin
        if (!endedRight) begin
          leftQ <= sample;
        end else begin
          pairL <= leftQ;
          pairR <= sample;
        end
      end
    end
  end

  // R8: a completed pair appears only when a right word closes
  assert_pair_on_right_R8: assert property (@(posedge clk) disable iff (rst)
    !(bitTick && wsEdge && endedRight) |=> ($stable(pairL) && $stable(pairR)));
endmodule

// File: rtl/tsb_dpath.sv
`timescale 1ns/1ps
module tsb_dpath
  import tsb_pkg::*;
#(
  parameter int SLOTS       = 8,
  parameter int SLOT_BITS   = 32,
  parameter int SAMPLE_BITS = 24,
  localparam int FRAME_BITS = SLOTS * SLOT_BITS,
  localparam int IDX_W      = $clog2(FRAME_BITS),
  localparam int SLOT_W     = $clog2(SLOT_BITS),
  localparam int SLOT_IDX_W = $clog2(SLOTS),
  localparam int SEL_W      = SLOT_IDX_W - 1,
  localparam int PAD        = SLOT_BITS - SAMPLE_BITS
) (
  input  logic             clk,
  input  logic             rst,
  input  tsb_strobe_t      strb,
  input  logic [IDX_W-1:0] bitIdx,
  input  logic             adcTdmIn,
  input  logic             stereoIn,
  input  logic             extAdcIn,
  input  logic             loopMode,
  input  logic [SEL_W-1:0] pairSel,
  output logic             dacTdmOut,
  output logic             stereoOut
);
  typedef logic [SAMPLE_BITS-1:0] sample_t;
  localparam int LINK_STEREO = 0;
  localparam int LINK_EXT    = 1;

  logic [SLOT_IDX_W-1:0] slotNum;
  logic [SLOT_W-1:0]     bitInSlot;
  assign slotNum   = bitIdx[IDX_W-1:SLOT_W];
  assign bitInSlot = bitIdx[SLOT_W-1:0];

  // Two-channel receivers: stereo input and external ADC
  logic [1:0] linkIn;
  sample_t    linkL [2];
  sample_t    linkR [2];
  assign linkIn = {extAdcIn, stereoIn};

  for (genvar g = 0; g < 2; g++) begin : g_link
    tsb_i2s_rx #(
      .SLOT_BITS  (SLOT_BITS),
      .SAMPLE_BITS(SAMPLE_BITS)
    ) u_rx (
      .clk       (clk),
      .rst       (rst),
      .bitTick   (strb.i2sTick),
      .wsEdge    (strb.wsEdge),
      .endedRight(strb.endedRight),
      .din       (linkIn[g]),
      .pairL     (linkL[g]),
      .pairR     (linkR[g])
    );
  end

  // TDM ADC capture
  logic [SLOT_BITS-2:0] rxSh;
  logic [SLOT_BITS-1:0] rxWord;
  sample_t              rxSample;
  sample_t              rxSlot  [SLOTS];
  sample_t              doneSlot[SLOTS];
  sample_t              nextDac [SLOTS];
  sample_t              dacHold [SLOTS];
  sample_t              txL, txR;
  logic [SLOT_BITS-1:0] dacWord;
  logic [SLOT_BITS-1:0] txSh;

  assign rxWord   = {rxSh, adcTdmIn};
  assign rxSample = rxWord[SLOT_BITS-1 -: SAMPLE_BITS];

  // The last slot finishes on the boundary strobe itself
  always_comb begin
    for (int s = 0; s < SLOTS; s++) begin
      doneSlot[s] = (s == SLOTS - 1) ? rxSample : rxSlot[s];
    end
  end

  // Routing of the next outgoing frame
  always_comb begin
    for (int s = 0; s < SLOTS; s++) begin
      if (loopMode && s < SLOTS - 2)
        nextDac[s] = doneSlot[s];
      else if (loopMode)
        nextDac[s] = (s % 2 == 0) ? linkL[LINK_EXT] : linkR[LINK_EXT];
      else
        nextDac[s] = (s % 2 == 0) ? linkL[LINK_STEREO] : linkR[LINK_STEREO];
    end
  end

  assign dacWord = {dacHold[slotNum], {PAD{1'b0}}};

  always_ff @(posedge clk) begin
    if (rst) begin
      rxSh      <= '0;
      txL       <= '0;
      txR       <= '0;
      dacTdmOut <= 1'b0;
      for (int s = 0; s < SLOTS; s++) begin
        rxSlot[s]  <= '0;
        dacHold[s] <= '0;
      end
    end else begin
      if (strb.tdmTick) begin
        rxSh      <= rxWord[SLOT_BITS-2:0];
        dacTdmOut <= dacWord[~bitInSlot];
      end
      if (strb.slotEnd) rxSlot[slotNum] <= rxSample;
      if (strb.frameEdge) begin
        for (int s = 0; s < SLOTS; s++) dacHold[s] <= nextDac[s];
        txL <= doneSlot[{pairSel, 1'b0}];
        txR <= doneSlot[{pairSel, 1'b1}];
      end
    end
  end

  // Two-channel transmitter with one-bit delay after each word clock change
  always_ff @(posedge clk) begin
    if (rst) begin
      txSh      <= '0;
      stereoOut <= 1'b0;
    end else if (strb.wsEdge) begin
      stereoOut <= 1'b0;
      txSh      <= {(strb.wsNow ? txR : txL), {PAD{1'b0}}};
    end else if (strb.i2sTick) begin
      stereoOut <= txSh[SLOT_BITS-1];
      txSh      <= {txSh[SLOT_BITS-2:0], 1'b0};
    end
  end

  // R10: routed data changes only at a frame boundary
  assert_hold_at_edge_R10: assert property (@(posedge clk) disable iff (rst)
    !strb.frameEdge |=> ($stable(txL) && $stable(txR) &&
                         $stable(dacHold[0]) && $stable(dacHold[SLOTS-1])));

  // R2: padding bits of every DAC slot are zero
  assert_pad_zero_R2: assert property (@(posedge clk) disable iff (rst)
    (strb.tdmTick && (int'(bitInSlot) >= SAMPLE_BITS)) |=> !dacTdmOut);

  // R8: the first bit after a word clock change is the zero delay bit
  assert_delay_bit_R8: assert property (@(posedge clk) disable iff (rst)
    strb.wsEdge |=> !stereoOut);

  // R7: loopback fills the last pair from the external ADC
  assert_loop_ext_R7: assert property (@(posedge clk) disable iff (rst)
    (strb.frameEdge && loopMode) |=>
      ((dacHold[SLOTS-2] == $past(linkL[LINK_EXT])) &&
       (dacHold[SLOTS-1] == $past(linkR[LINK_EXT]))));
endmodule

// File: rtl/tdm_stereo_bridge.sv
`timescale 1ns/1ps
module tdm_stereo_bridge
  import tsb_pkg::*;
#(
  parameter int SLOTS       = 8,
  parameter int SLOT_BITS   = 32,
  parameter int SAMPLE_BITS = 24,
  localparam int FRAME_BITS = SLOTS * SLOT_BITS,
  localparam int IDX_W      = $clog2(FRAME_BITS),
  localparam int SEL_W      = $clog2(SLOTS) - 1
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             tdmBitEn,
  input  logic             tdmFsync,
  input  logic             adcTdmIn,
  output logic             dacTdmOut,
  input  logic             i2sBitEn,
  input  logic             i2sWordClk,
  input  logic             stereoIn,
  input  logic             extAdcIn,
  output logic             stereoOut,
  input  logic             loopMode,
  input  logic [SEL_W-1:0] pairSel
);
  tsb_strobe_t      strb;
  logic [IDX_W-1:0] bitIdx;

  tsb_ctrl #(
    .FRAME_BITS(FRAME_BITS),
    .SLOT_BITS (SLOT_BITS)
  ) u_ctrl (
    .clk       (clk),
    .rst       (rst),
    .tdmBitEn  (tdmBitEn),
    .tdmFsync  (tdmFsync),
    .i2sBitEn  (i2sBitEn),
    .i2sWordClk(i2sWordClk),
    .strb      (strb),
    .bitIdx    (bitIdx)
  );

  tsb_dpath #(
    .SLOTS      (SLOTS),
    .SLOT_BITS  (SLOT_BITS),
    .SAMPLE_BITS(SAMPLE_BITS)
  ) u_dpath (
    .clk      (clk),
    .rst      (rst),
    .strb     (strb),
    .bitIdx   (bitIdx),
    .adcTdmIn (adcTdmIn),
    .stereoIn (stereoIn),
    .extAdcIn (extAdcIn),
    .loopMode (loopMode),
    .pairSel  (pairSel),
    .dacTdmOut(dacTdmOut),
    .stereoOut(stereoOut)
  );
endmodule

// File: tb/tdm_stereo_bridge_tb.sv
`timescale 1ns/1ps
module tdm_stereo_bridge_tb;
  localparam int RESET_CYC = 8;
  localparam int FRAMES    = 30;
  localparam int TOTAL     = RESET_CYC + FRAMES * 512;

  logic clk = 1'b0;
  always #2 clk = ~clk;   // 250 MHz

  logic rst, tdmBitEn, tdmFsync, adcTdmIn, i2sBitEn, i2sWordClk;
  logic stereoIn, extAdcIn, loopMode;
  logic [1:0] pairSel;
  logic dacTdmOut, stereoOut;

  tdm_stereo_bridge u_dut (
    .clk(clk), .rst(rst), .tdmBitEn(tdmBitEn), .tdmFsync(tdmFsync),
    .adcTdmIn(adcTdmIn), .dacTdmOut(dacTdmOut), .i2sBitEn(i2sBitEn),
    .i2sWordClk(i2sWordClk), .stereoIn(stereoIn), .extAdcIn(extAdcIn),
    .stereoOut(stereoOut), .loopMode(loopMode), .pairSel(pairSel)
  );

  int compared = 0;
  int mismatched = 0;
  bit done = 0;

  // Reference model state
  logic [31:0] adcW [8];
  logic [23:0] outF [8];
  logic [23:0] txPL, txPR;
  logic [23:0] stCur [2], stLatest [2], exCur [2], exLatest [2];
  logic [31:0] txShift;
  bit synced, primed, modeUsed;
  bit expDac, expTx;
  string tagDac, tagTx;

  task automatic check(input string tag, input logic act, input bit exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s: actual %b expected %0b at %0t", tag, act, exp, $time);
    end
  endtask

  function automatic bit linkBit(input logic [23:0] l, input logic [23:0] r, input int j);
    if (j >= 1 && j <= 24) return l[24 - j];
    if (j >= 33 && j <= 56) return r[56 - j];
    return bit'($urandom() & 1);   // ignored padding bits
  endfunction

  task automatic step(input int c);
    int f, p, idx, slot, b, j, m;
    f = c / 512;
    p = c % 512;
    // Routing changes: mid-frame, on the sync strobe, and right after it (R10)
    if (p == 200) begin
      pairSel  = 2'(f % 4);
      loopMode = (f % 3 == 1);
    end
    if (p == 510 && f % 5 == 2) loopMode = !loopMode;
    if (p == 511 && f % 7 == 3) pairSel = pairSel + 2'd1;

    // TDM side
    idx = (c / 2) % 256;
    tdmBitEn = (c % 2 == 0);
    tdmFsync = tdmBitEn && (idx == 255);
    if (tdmBitEn) begin
      slot = idx / 32;
      b = idx % 32;
      adcTdmIn = adcW[slot][31 - b];
      expDac = (b < 24) ? outF[slot][23 - b] : 1'b0;
      if (!primed) tagDac = "R11";
      else if (b >= 24) tagDac = "R2";
      else if (modeUsed) tagDac = (slot < 6) ? "R6 R4 R9 R10" : "R7 R10";
      else tagDac = "R3 R1 R9 R10";
      if (idx == 255) begin
        if (synced) begin
          for (int s = 0; s < 8; s++) begin
            if (loopMode) outF[s] = (s < 6) ? adcW[s][31:8] : ((s % 2 == 0) ? exLatest[0] : exLatest[1]);
            else outF[s] = (s % 2 == 0) ? stLatest[0] : stLatest[1];
          end
          txPL = adcW[2 * pairSel][31:8];
          txPR = adcW[2 * pairSel + 1][31:8];
          modeUsed = loopMode;
          primed = 1;
        end
        synced = 1;
        for (int s = 0; s < 8; s++) adcW[s] = $urandom();
      end
    end else begin
      adcTdmIn = bit'($urandom() & 1);
    end

    // Two-channel side
    j = (c / 8) % 64;
    m = c / 512;
    i2sBitEn = (c % 8 == 1);
    if (i2sBitEn) begin
      if (j == 0) begin
        if (m > 0) begin
          stLatest = stCur;
          exLatest = exCur;
        end
        for (int k = 0; k < 2; k++) begin
          stCur[k] = 24'($urandom());
          exCur[k] = 24'($urandom());
        end
      end
      i2sWordClk = (j >= 32);
      stereoIn = linkBit(stCur[0], stCur[1], j);
      extAdcIn = linkBit(exCur[0], exCur[1], j);
      if (j == 0 || j == 32) begin
        expTx = 1'b0;
        txShift = {((j == 0) ? txPL : txPR), 8'h00};
        tagTx = primed ? "R8" : "R11";
      end else begin
        expTx = txShift[31];
        txShift = txShift << 1;
        tagTx = primed ? "R5 R8 R10" : "R11";
      end
    end else begin
      stereoIn = bit'($urandom() & 1);
      extAdcIn = bit'($urandom() & 1);
    end
  endtask

  initial begin
    rst = 1; tdmBitEn = 0; tdmFsync = 0; adcTdmIn = 0; i2sBitEn = 0;
    i2sWordClk = 0; stereoIn = 0; extAdcIn = 0; loopMode = 0; pairSel = 0;
    for (int s = 0; s < 8; s++) begin
      adcW[s] = $urandom();
      outF[s] = '0;
    end
    for (int k = 0; k < 2; k++) begin
      stCur[k] = '0; stLatest[k] = '0; exCur[k] = '0; exLatest[k] = '0;
    end
    txPL = '0; txPR = '0; txShift = '0;
    synced = 0; primed = 0; modeUsed = 0;
    expDac = 0; expTx = 0; tagDac = "R12"; tagTx = "R12";
    for (int n = 0; n < TOTAL; n++) begin
      @(negedge clk);
      if (n > 0) begin
        check(tagDac, dacTdmOut, expDac);
        check(tagTx, stereoOut, expTx);
      end
      if (n < RESET_CYC) begin
        rst = 1;   // R12: outputs held at zero
        expDac = 0; expTx = 0; tagDac = "R12"; tagTx = "R12";
      end else begin
        rst = 0;
        step(n - RESET_CYC);
      end
    end
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      mismatched++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end
endmodule